// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit general-register value into a floating-point number in double-precision format. A two-bit type code selects whether the source is a 32-bit or 64-bit integer, and whether it is signed or unsigned. A precision select chooses the target format:

- With the select low, the target is full double precision.
- With the select high, the value is rounded to single precision and then carried in double format.

Conversions that can lose bits round according to a two-bit dynamic rounding mode. These conversions report three pieces of status:

- an inexact flag,
- a rounded-up flag,
- a five-bit result-class code.

A flag-update enable tells the surrounding unit whether those flags should be merged into its status register. A 32-bit integer converted to double precision always fits exactly, so that path holds the enable low and leaves the status untouched.

The converter is a single pipeline stage. An operand presented with `in_valid` appears on the outputs one clock later, with `out_valid` high. Status accumulation and condition-register updates belong to the caller.

Top module: `i2f_conv`

## Requirements
- R1: Type code `int_type` selects the source as follows: 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit. The 32-bit types read only `operand[31:0]`; the upper word has no effect on any output.
- R2: When `int_type[1]` is 0 and `to_single` is 0, `flags_we` is 0 and the result is the exact double value of the integer.
- R3: When `int_type[1]` is 1 or `to_single` is 1, `flags_we` is 1.
- R4: Rounding mode `rmode` is encoded as 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. Rounding toward zero never sets the rounded-up flag.
- R5: `flag_inexact` is 1 exactly when nonzero bits were discarded. `flag_roundup` is 1 exactly when the magnitude was incremented, so it implies `flag_inexact`.
- R6: A zero integer produces +0.0 (all 64 bits zero) with class code 5'b00010 when flags are enabled.
- R7: The class code is 5'b01000 for a positive nonzero result and 5'b11000 for a negative one. Unsigned sources never give a negative result.
- R8: With `to_single` set, the significand is rounded to 24 bits and the result is that single value in double format. Its low 29 fraction bits `result[28:0]` are zero.
- R9: `out_valid` equals `in_valid` delayed by one clock. After reset all outputs are zero.
- R10: While `flags_we` is 0, `flag_inexact`, `flag_roundup` and `fclass` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 64 | Integer source value |
| int_type | input | 2 | Integer type code (R1) |
| to_single | input | 1 | Round to single precision |
| rmode | input | 2 | Rounding mode (R4) |
| out_valid | output | 1 | Result present |
| result | output | 64 | Double-format float result |
| flag_inexact | output | 1 | Bits were lost in rounding |
| flag_roundup | output | 1 | Magnitude was incremented |
| fclass | output | 5 | Result class code |
| flags_we | output | 1 | Status flags should be merged |

## Verification
The assertions assume that `in_valid` and the other inputs are known and settled at each rising edge. They also assume every two-bit `rmode` value is a legal mode. The bench respects both by changing inputs only on falling edges. It draws operand, type, precision and mode from the full range, since no encoding is illegal. Directed cases cover the corners:

- the zero-and-garbage upper word,
- the most negative 64-bit value,
- all-ones unsigned values that carry into a new exponent,
- exact ties under nearest-even.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
    localparam int INT_W     = 64;
    localparam int DBL_SIG   = 53;
    localparam int SGL_SIG   = 24;
    localparam int EXP_W     = 11;
    localparam int DBL_BIAS  = 1023;
    localparam int LZ_W      = $clog2(INT_W) + 1;
    localparam int FRAC_W    = DBL_SIG - 1;
    localparam int PAD_W     = DBL_SIG - SGL_SIG;

    localparam logic [1:0] RM_NEAR = 2'b00;
    localparam logic [1:0] RM_ZERO = 2'b01;
    localparam logic [1:0] RM_POS  = 2'b10;
    localparam logic [1:0] RM_NEG  = 2'b11;

    localparam logic [4:0] CLS_PZERO = 5'b00010;
    localparam logic [4:0] CLS_PNORM = 5'b01000;
    localparam logic [4:0] CLS_NNORM = 5'b11000;

    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] result;
        logic             inexact;
        logic             roundup;
        logic [4:0]       fclass;
        logic             flags_we;
    } conv_state_t;
endpackage

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
    parameter int W   = 64,
    parameter int CNT = $clog2(W) + 1
) (
    input  logic [W-1:0]   value,
    output logic [CNT-1:0] lz,
    output logic           is_zero
);
    logic [CNT-1:0] msb;

    always_comb begin
        msb = '0;
        for (int i = 0; i < W; i++) begin
            if (value[i]) msb = CNT'(i);
        end
        is_zero = (value == '0);
        lz      = is_zero ? CNT'(W) : CNT'(W - 1) - msb;
    end
endmodule

// File: rtl/i2f_round.sv
module i2f_round #(
    parameter int IN_W  = 64,
    parameter int SIG_W = 53
) (
    input  logic [IN_W-1:0]  norm,
    input  logic             neg,
    input  logic [1:0]       rmode,
    output logic [SIG_W-1:0] sig,
    output logic             carry,
    output logic             inexact,
    output logic             inc
);
    import i2f_pkg::*;

    localparam int LOW = IN_W - 1 - SIG_W;

    logic [SIG_W-1:0] kept;
    logic             guard;
    logic             sticky;
    logic [SIG_W:0]   sum;

    always_comb begin
        kept    = norm[IN_W-1 -: SIG_W];
        guard   = norm[LOW];
        sticky  = |norm[LOW-1:0];
        inexact = guard | sticky;
        unique case (rmode)
            RM_NEAR: inc = guard & (sticky | kept[0]);
            RM_ZERO: inc = 1'b0;
            RM_POS:  inc = inexact & ~neg;
            default: inc = inexact & neg;
        endcase
        sum   = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
        carry = sum[SIG_W];
        sig   = sum[SIG_W-1:0];
    end
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
    import i2f_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] operand,
    input  logic [1:0]  int_type,
    input  logic        to_single,
    input  logic [1:0]  rmode,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        flag_inexact,
    output logic        flag_roundup,
    output logic [4:0]  fclass,
    output logic        flags_we
);
    conv_state_t st_d, st_q;

    logic             neg;
    logic [INT_W-1:0] ext;
    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] norm;
    logic [LZ_W-1:0]  lz;
    logic             mag_zero;

    logic [DBL_SIG-1:0] rsig    [2];
    logic               rcarry  [2];
    logic               rinexact[2];
    logic               rinc    [2];

    always_comb begin
        if (int_type[1]) begin
            ext = operand;
            neg = ~int_type[0] & operand[63];
        end else begin
            ext = int_type[0] ? {32'b0, operand[31:0]}
                              : {{32{operand[31]}}, operand[31:0]};
            neg = ~int_type[0] & operand[31];
        end
        mag = neg ? (INT_W'(0) - ext) : ext;
    end

    i2f_lzc #(.W(INT_W), .CNT(LZ_W)) i_lzc (
        .value   (mag),
        .lz      (lz),
        .is_zero (mag_zero)
    );

    assign norm = mag << lz;

    for (genvar g = 0; g < 2; g++) begin : g_prec
        localparam int SW = (g == 0) ? DBL_SIG : SGL_SIG;
        logic [SW-1:0] sig_w;
        i2f_round #(.IN_W(INT_W), .SIG_W(SW)) i_round (
            .norm    (norm),
            .neg     (neg),
            .rmode   (rmode),
            .sig     (sig_w),
            .carry   (rcarry[g]),
            .inexact (rinexact[g]),
            .inc     (rinc[g])
        );
        assign rsig[g] = DBL_SIG'(sig_w);
    end

    always_comb begin
        logic [EXP_W-1:0]  bexp;
        logic [FRAC_W-1:0] frac;
        logic              sel;
        logic              we;

        sel  = to_single;
        we   = int_type[1] | to_single;
        bexp = EXP_W'(DBL_BIAS + INT_W - 1) - EXP_W'(lz)
             + {{(EXP_W-1){1'b0}}, rcarry[sel]};
        frac = sel ? {rsig[1][SGL_SIG-2:0], {PAD_W{1'b0}}}
                   : rsig[0][FRAC_W-1:0];

        st_d = '0;
        if (in_valid) begin
            st_d.valid    = 1'b1;
            st_d.flags_we = we;
            if (!mag_zero) begin
                st_d.result = {neg, bexp, frac};
            end
            if (we) begin
                st_d.inexact = ~mag_zero & rinexact[sel];
                st_d.roundup = ~mag_zero & rinc[sel];
                st_d.fclass  = mag_zero ? CLS_PZERO
                             : (neg ? CLS_NNORM : CLS_PNORM);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign result       = st_q.result;
    assign flag_inexact = st_q.inexact;
    assign flag_roundup = st_q.roundup;
    assign fclass       = st_q.fclass;
    assign flags_we     = st_q.flags_we;

    p_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_exact_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !int_type[1] && !to_single |=> out_valid && !flags_we);
    p_round_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (int_type[1] || to_single) |=> flags_we);
    p_rz_noup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rmode == RM_ZERO |=> !flag_roundup);
    p_up_implies_ix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_roundup |-> flag_inexact);
    p_zero_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (int_type[1] ? operand == 64'd0 : operand[31:0] == 32'd0)
        |=> result == 64'd0);
    p_unsigned_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && int_type[0] |=> !result[63]);
    p_single_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && to_single |=> result[28:0] == 29'd0);
    p_quiet_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !flags_we |-> !flag_inexact && !flag_roundup && fclass == 5'd0);
endmodule

// File: tb/test_i2f_conv.sv
module test_i2f_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  int_type = '0;
    logic        to_single = 1'b0;
    logic [1:0]  rmode = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_inexact;
    logic        flag_roundup;
    logic [4:0]  fclass;
    logic        flags_we;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    typedef struct packed {
        logic [63:0] r;
        logic        ix;
        logic        ru;
        logic [4:0]  c;
        logic        we;
    } exp_t;

    i2f_conv i_i2f_conv (
        .clk, .rst_n, .in_valid, .operand, .int_type, .to_single, .rmode,
        .out_valid, .result, .flag_inexact, .flag_roundup, .fclass, .flags_we
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    function automatic exp_t model(logic [63:0] op, logic [1:0] t, logic s, logic [1:0] rm);
        exp_t        m;
        logic        neg;
        logic [63:0] v;
        logic [64:0] mag, kept, rem, half;
        logic        lost, up;
        int          p, prec, sh;
        logic [10:0] e;
        m = '0;
        if (t[1]) begin
            v = op; neg = !t[0] && op[63];
        end else begin
            v = t[0] ? {32'b0, op[31:0]} : {{32{op[31]}}, op[31:0]};
            neg = !t[0] && op[31];
        end
        mag  = {1'b0, neg ? (~v + 64'd1) : v};
        m.we = t[1] | s;
        if (mag == 0) begin
            m.c = 5'b00010;
        end else begin
            p = 0;
            for (int i = 0; i < 64; i++) if (mag[i]) p = i;
            prec = s ? 24 : 53;
            lost = 1'b0; up = 1'b0;
            if (p < prec) begin
                kept = mag << (prec - 1 - p);
            end else begin
                sh   = p - prec + 1;
                kept = mag >> sh;
                rem  = mag & ((65'd1 << sh) - 65'd1);
                half = 65'd1 << (sh - 1);
                lost = rem != 0;
                case (rm)
                    2'b00: up = (rem > half) || (rem == half && kept[0]);
                    2'b01: up = 1'b0;
                    2'b10: up = lost && !neg;
                    default: up = lost && neg;
                endcase
                if (up) kept = kept + 65'd1;
                if (kept[prec]) begin kept = kept >> 1; p++; end
            end
            e = 11'(1023 + p);
            m.r  = s ? {neg, e, kept[22:0], 29'b0} : {neg, e, kept[51:0]};
            m.c  = neg ? 5'b11000 : 5'b01000;
            m.ix = lost;
            m.ru = up;
        end
        if (!m.we) begin m.ix = 1'b0; m.ru = 1'b0; m.c = '0; end
        return m;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(logic [63:0] op, logic [1:0] t, logic s, logic [1:0] rm, string tag);
        exp_t e;
        e = model(op, t, s, rm);
        @(negedge clk);
        operand = op; int_type = t; to_single = s; rmode = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R9 valid"}, {63'd0, out_valid}, 64'd1);
        chk({tag, " result"}, result, e.r);
        chk({tag, " R10 flags"}, {55'd0, flag_inexact, flag_roundup, fclass, flags_we},
            {55'd0, e.ix, e.ru, e.c, e.we});
    endtask

    task automatic expect_word(logic [63:0] op, logic [1:0] t, logic s, logic [1:0] rm,
                               logic [63:0] exp, string tag);
        @(negedge clk);
        operand = op; int_type = t; to_single = s; rmode = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(tag, result, exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R9 reset outputs", {out_valid, flag_inexact, flag_roundup, fclass, flags_we, 54'd0}, 64'd0);
        chk("R9 reset result", result, 64'd0);
        rst_n = 1'b1;

        expect_word(64'hDEAD_BEEF_0000_0000, 2'd0, 1'b0, 2'b00, 64'd0, "R1 R6 upper word ignored");
        run(64'hDEAD_BEEF_0000_0000, 2'd0, 1'b1, 2'b00, "R6 zero class");
        expect_word(64'h1234_5678_0000_0001, 2'd0, 1'b0, 2'b00, 64'h3FF0_0000_0000_0000, "R1 one");
        expect_word(64'h0000_0000_FFFF_FFFF, 2'd0, 1'b0, 2'b00, 64'hBFF0_0000_0000_0000, "R7 minus one");
        expect_word(64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b0, 2'b00, 64'h41EF_FFFF_FFE0_0000, "R1 R2 u32 max");
        run(64'h0000_0000_FFFF_FFFF, 2'd1, 1'b0, 2'b10, "R2 exact path");
        expect_word(64'h0000_0000_FFFF_FFFF, 2'd1, 1'b1, 2'b00, 64'h41F0_0000_0000_0000, "R8 single carry");
        run(64'h0000_0000_FFFF_FFFF, 2'd1, 1'b1, 2'b00, "R5 R8 single roundup");
        expect_word(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'b00, 64'hC3E0_0000_0000_0000, "R7 s64 min");
        run(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'b01, "R4 toward zero");
        run(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'b10, "R4 toward pos");
        run(64'h8000_0000_0000_0401, 2'd2, 1'b0, 2'b11, "R4 toward neg");
        run(64'h8000_0000_0000_0401, 2'd2, 1'b0, 2'b10, "R4 neg toward pos");
        run(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'b00, "R5 tie even down");
        run(64'h0020_0000_0000_0003, 2'd3, 1'b0, 2'b00, "R5 tie odd up");
        run(64'h0000_0000_0100_0001, 2'd1, 1'b1, 2'b00, "R8 single tie");
        run(64'h0000_0000_0000_0000, 2'd3, 1'b0, 2'b01, "R3 R6 u64 zero");

        @(negedge clk);
        chk("R9 idle after result", {63'd0, out_valid}, 64'd0);

        for (int k = 0; k < 400; k++) begin
            logic [63:0] op;
            logic [1:0]  t, rm;
            logic        s;
            op = {$urandom, $urandom};
            if (k % 4 == 1) op = op >> ($urandom % 64);
            t  = 2'($urandom);
            s  = 1'($urandom);
            rm = 2'($urandom);
            run(op, t, s, rm, (t[1] | s) ? "R3 R4 R7 random" : "R1 R2 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule